// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Read Cycle Generator

This block runs one read access on an external memory whose address and data share one set of bus wires. A request carries the address. From that point a tick counter runs, and each strobe edge fires at its own programmed tick. The strobes are chip select, address-valid and output-enable, all active-low and registered. The block also drives a direction line and the enable of the shared-bus output driver. The address is on the bus until the data phase begins. The read data is captured at a programmed access tick, and a one-cycle result pulse is raised at the programmed cycle end.

In the optional two-phase mode the address is twice as wide as the bus and is sent in two halves, upper half first. Address-valid and output-enable each pulse twice per read, and the first pulse of each has its own short on and off ticks. Between accesses the block drives the shared bus with the last data it read, so the wires never float.

The request side uses a valid/ready handshake. `req_ready` is high only while idle, and a request is accepted on any clock where both are high. The result side has no back-pressure: `rd_valid` is a single-cycle pulse, and the consumer must take `rd_data` in that cycle.

Top module: `mux_rd_timer`

## Requirements
- R1: `req_ready` is high exactly while no access runs. A request is accepted when `req_valid` and `req_ready` are both high. The cycle after acceptance shows tick 0, and each later cycle advances the tick by one. `req_valid` raised during an access has no effect, and the tick sequence continues unchanged.
- R2: Chip select (`cs_n`) is low during tick k exactly when cs_on <= k < cs_off. cs_on is 4 bits and cs_off is 5 bits. If cs_off <= cs_on, chip select stays high for the whole access.
- R3: In single-address mode, address-valid (`adv_n`) is low during tick k exactly when adv_on <= k < adv_off. adv_on is 4 bits and adv_off is 5 bits.
- R4: In single-address mode, output-enable (`oe_n`) is low during tick k exactly when oe_on <= k < oe_off. oe_on is 4 bits and oe_off is 5 bits.
- R5: During ticks k < oe_on, `bus_oe`=1, `dir_out`=1 (1 means the block drives outward), and in single-address mode `bus_out` = `req_addr[BUS_W-1:0]`. From tick oe_on until the access ends, `bus_oe`=0 and `dir_out`=0.
- R6: `rd_data` takes the value `bus_in` had during tick acc. The access spans ticks 0 to cyc. `rd_valid` is high for exactly the one cycle after tick cyc, and in that cycle all strobes are high and `req_ready` is 1. If acc > cyc, `rd_data` keeps its previous value.
- R7: In two-phase mode, during address ticks k < oe_on, `bus_out` = `req_addr[2*BUS_W-1:BUS_W]` while k < oe1_off. From oe1_off onward it is `req_addr[BUS_W-1:0]`.
- R8: In two-phase mode, `adv_n` is low during tick k when k lies in either window: adv1_on <= k < adv1_off (3-bit values) or adv_on <= k < adv_off.
- R9: In two-phase mode, `oe_n` is low during tick k when k lies in either window: oe1_on <= k < oe1_off (3-bit values) or oe_on <= k < oe_off.
- R10: Whenever no access runs, `bus_oe`=1, `dir_out`=1 and `bus_out` equals the last captured read data. That value is 0 after reset.
- R11: All configuration inputs and the address are sampled at acceptance. Changing them during an access has no effect on that access.
- R12: After reset, `cs_n`, `adv_n` and `oe_n` are all 1, `req_ready`=1, `rd_valid`=0, `dir_out`=1, `bus_oe`=1 and `bus_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request |
| req_ready | output | 1 | Idle, request can be taken |
| req_addr | input | 2*BUS_W | Read address |
| cfg_two_phase | input | 1 | 1 selects two-phase address mode |
| cfg_cs_on | input | ON_W | Chip-select on tick |
| cfg_cs_off | input | T_W | Chip-select off tick |
| cfg_adv_on | input | ON_W | Address-valid on tick |
| cfg_adv_off | input | T_W | Address-valid off tick |
| cfg_oe_on | input | ON_W | Output-enable on tick, start of data phase |
| cfg_oe_off | input | T_W | Output-enable off tick |
| cfg_acc | input | T_W | Data capture tick |
| cfg_cyc | input | T_W | Last tick of the access |
| cfg_adv1_on | input | P1_W | First address-valid pulse on tick |
| cfg_adv1_off | input | P1_W | First address-valid pulse off tick |
| cfg_oe1_on | input | P1_W | First output-enable pulse on tick |
| cfg_oe1_off | input | P1_W | First output-enable pulse off tick, switch to lower half |
| bus_in | input | BUS_W | Shared bus as seen at the pins |
| bus_out | output | BUS_W | Value driven onto the shared bus |
| bus_oe | output | 1 | Shared-bus output driver enable |
| dir_out | output | 1 | Direction, 1 = outward |
| cs_n | output | 1 | Chip select, active-low |
| adv_n | output | 1 | Address valid, active-low |
| oe_n | output | 1 | Output enable, active-low |
| rd_valid | output | 1 | One-cycle result pulse |
| rd_data | output | BUS_W | Captured read data |

## Verification
The bench builds the block with its default widths: a 16-bit bus, 4-bit on ticks, 5-bit off, access and cycle ticks, and 3-bit first-pulse ticks. It sweeps every chip-select on value (0 to 15) against every off value (0 to 31). The other edge ticks, the access tick, the cycle length and the address mode are derived arithmetically from the two loop indices, so empty windows, access ticks beyond the cycle end, and zero-length cycles are all reached in both address modes. During every access the configuration and address inputs are scrambled and a stray request is raised. This confirms that only the values taken at acceptance steer the strobes, the bus halves and the capture tick.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  // Indices of the programmable strobe windows.
  localparam int S_CS   = 0;
  localparam int S_ADV2 = 1;
  localparam int S_OE2  = 2;
  localparam int S_ADV1 = 3;
  localparam int S_OE1  = 4;
  localparam int S_NUM  = 5;
endpackage

// File: rtl/mrt_window.sv
// One programmable window: active while on <= tick < off.
module mrt_window #(
  parameter int T_W = 5
) (
  input  logic [T_W-1:0] on_tick,
  input  logic [T_W-1:0] off_tick,
  input  logic [T_W-1:0] tick,
  output logic           active
);
  always_comb active = (tick >= on_tick) && (tick < off_tick);
endmodule

// File: rtl/mrt_seq.sv
// Access sequencer: idle/busy state, tick counter, done pulse.
module mrt_seq #(
  parameter int T_W = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [T_W-1:0] cyc_q,
  output logic           busy,
  output logic [T_W-1:0] tick,
  output logic           start,
  output logic           run_nxt,
  output logic [T_W-1:0] tick_nxt,
  output logic           done
);
  logic           busy_q;
  logic [T_W-1:0] cnt_q;
  logic           done_q;
  logic           last;

  always_comb begin
    start    = req_valid && !busy_q;
    last     = busy_q && (cnt_q == cyc_q);
    run_nxt  = start || (busy_q && !last);
    tick_nxt = start ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= run_nxt;
      if (run_nxt) cnt_q <= tick_nxt;
      done_q <= last;
    end
  end

  assign busy = busy_q;
  assign tick = cnt_q;
  assign done = done_q;
endmodule

// File: rtl/mrt_bus.sv
// Shared-bus side: address phases, direction, capture and bus keeping.
module mrt_bus #(
  parameter int BUS_W = 16,
  parameter int T_W   = 5,
  localparam int ADDR_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              busy,
  input  logic [T_W-1:0]    tick,
  input  logic              run_nxt,
  input  logic [T_W-1:0]    tick_nxt,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              two_sel,
  input  logic [T_W-1:0]    oe_on_sel,
  input  logic [T_W-1:0]    oe1_off_sel,
  input  logic [T_W-1:0]    acc_q,
  input  logic [BUS_W-1:0]  bus_in,
  output logic [BUS_W-1:0]  bus_out,
  output logic              bus_oe,
  output logic              dir_out,
  output logic [BUS_W-1:0]  rd_data
);
  logic [ADDR_W-1:0] addr_q, addr_sel;
  logic [BUS_W-1:0]  rdata_q, rdata_nxt, out_q, out_nxt;
  logic              drive_q, drive_nxt, dir_q, dir_nxt;
  logic              addr_phase, hi_phase;

  always_comb begin
    addr_sel   = start ? req_addr : addr_q;
    rdata_nxt  = (busy && (tick == acc_q)) ? bus_in : rdata_q;
    addr_phase = tick_nxt < oe_on_sel;
    hi_phase   = two_sel && (tick_nxt < oe1_off_sel);
    if (run_nxt) begin
      drive_nxt = addr_phase;
      dir_nxt   = addr_phase;
      if (!addr_phase)   out_nxt = '0;
      else if (hi_phase) out_nxt = addr_sel[ADDR_W-1:BUS_W];
      else               out_nxt = addr_sel[BUS_W-1:0];
    end else begin
      // idle: keep the last read value on the wires
      drive_nxt = 1'b1;
      dir_nxt   = 1'b1;
      out_nxt   = rdata_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rdata_q <= '0;
      out_q   <= '0;
      drive_q <= 1'b1;
      dir_q   <= 1'b1;
    end else begin
      if (start) addr_q <= req_addr;
      rdata_q <= rdata_nxt;
      out_q   <= out_nxt;
      drive_q <= drive_nxt;
      dir_q   <= dir_nxt;
    end
  end

  assign bus_out = out_q;
  assign bus_oe  = drive_q;
  assign dir_out = dir_q;
  assign rd_data = rdata_q;
endmodule

// File: rtl/mux_rd_timer.sv
module mux_rd_timer #(
  parameter int BUS_W = 16,
  parameter int ON_W  = 4,
  parameter int T_W   = 5,
  parameter int P1_W  = 3,
  localparam int ADDR_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              cfg_two_phase,
  input  logic [ON_W-1:0]   cfg_cs_on,
  input  logic [T_W-1:0]    cfg_cs_off,
  input  logic [ON_W-1:0]   cfg_adv_on,
  input  logic [T_W-1:0]    cfg_adv_off,
  input  logic [ON_W-1:0]   cfg_oe_on,
  input  logic [T_W-1:0]    cfg_oe_off,
  input  logic [T_W-1:0]    cfg_acc,
  input  logic [T_W-1:0]    cfg_cyc,
  input  logic [P1_W-1:0]   cfg_adv1_on,
  input  logic [P1_W-1:0]   cfg_adv1_off,
  input  logic [P1_W-1:0]   cfg_oe1_on,
  input  logic [P1_W-1:0]   cfg_oe1_off,
  input  logic [BUS_W-1:0]  bus_in,
  output logic [BUS_W-1:0]  bus_out,
  output logic              bus_oe,
  output logic              dir_out,
  output logic              cs_n,
  output logic              adv_n,
  output logic              oe_n,
  output logic              rd_valid,
  output logic [BUS_W-1:0]  rd_data
);
  import mrt_pkg::*;

  logic           busy, start, run_nxt;
  logic [T_W-1:0] tick, tick_nxt;
  logic [T_W-1:0] on_in  [S_NUM];
  logic [T_W-1:0] off_in [S_NUM];
  logic [T_W-1:0] on_q   [S_NUM];
  logic [T_W-1:0] off_q  [S_NUM];
  logic [T_W-1:0] on_sel [S_NUM];
  logic [T_W-1:0] off_sel[S_NUM];
  logic [S_NUM-1:0] act;
  logic           two_ph_q, two_sel;
  logic [T_W-1:0] acc_q, cyc_q;
  logic           cs_q, adv_q, oe_q;

  // widen programmed ticks to the counter width
  always_comb begin
    on_in[S_CS]   = T_W'(cfg_cs_on);   off_in[S_CS]   = cfg_cs_off;
    on_in[S_ADV2] = T_W'(cfg_adv_on);  off_in[S_ADV2] = cfg_adv_off;
    on_in[S_OE2]  = T_W'(cfg_oe_on);   off_in[S_OE2]  = cfg_oe_off;
    on_in[S_ADV1] = T_W'(cfg_adv1_on); off_in[S_ADV1] = T_W'(cfg_adv1_off);
    on_in[S_OE1]  = T_W'(cfg_oe1_on);  off_in[S_OE1]  = T_W'(cfg_oe1_off);
  end

  // configuration snapshot taken at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < S_NUM; i++) begin
        on_q[i]  <= '0;
        off_q[i] <= '0;
      end
      two_ph_q <= 1'b0;
      acc_q    <= '0;
      cyc_q    <= '0;
    end else if (start) begin
      for (int i = 0; i < S_NUM; i++) begin
        on_q[i]  <= on_in[i];
        off_q[i] <= off_in[i];
      end
      two_ph_q <= cfg_two_phase;
      acc_q    <= cfg_acc;
      cyc_q    <= cfg_cyc;
    end
  end

  always_comb begin
    two_sel = start ? cfg_two_phase : two_ph_q;
    for (int i = 0; i < S_NUM; i++) begin
      on_sel[i]  = start ? on_in[i]  : on_q[i];
      off_sel[i] = start ? off_in[i] : off_q[i];
    end
  end

  mrt_seq #(.T_W(T_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cyc_q(cyc_q),
    .busy(busy), .tick(tick), .start(start), .run_nxt(run_nxt),
    .tick_nxt(tick_nxt), .done(rd_valid)
  );

  for (genvar g = 0; g < S_NUM; g++) begin : g_win
    mrt_window #(.T_W(T_W)) u_win (
      .on_tick(on_sel[g]), .off_tick(off_sel[g]),
      .tick(tick_nxt), .active(act[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      adv_q <= 1'b1;
      oe_q  <= 1'b1;
    end else begin
      cs_q  <= !(run_nxt && act[S_CS]);
      adv_q <= !(run_nxt && (act[S_ADV2] || (two_sel && act[S_ADV1])));
      oe_q  <= !(run_nxt && (act[S_OE2]  || (two_sel && act[S_OE1])));
    end
  end

  mrt_bus #(.BUS_W(BUS_W), .T_W(T_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .tick(tick),
    .run_nxt(run_nxt), .tick_nxt(tick_nxt), .req_addr(req_addr),
    .two_sel(two_sel), .oe_on_sel(on_sel[S_OE2]),
    .oe1_off_sel(off_sel[S_OE1]), .acc_q(acc_q), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .dir_out(dir_out), .rd_data(rd_data)
  );

  assign req_ready = !busy;
  assign cs_n  = cs_q;
  assign adv_n = adv_q;
  assign oe_n  = oe_q;
endmodule

// File: rtl/mrt_chk.sv
module mrt_chk #(
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             cs_n,
  input logic             adv_n,
  input logic             oe_n,
  input logic             bus_oe,
  input logic             dir_out,
  input logic [BUS_W-1:0] bus_out,
  input logic             rd_valid,
  input logic [BUS_W-1:0] rd_data,
  input logic             two_ph_q
);
  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // idle cycles leave every strobe released
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n && adv_n && oe_n));

  assert_data_phase_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !two_ph_q && !oe_n) |-> (!dir_out && !bus_oe));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (req_ready && cs_n && adv_n && oe_n));

  assert_keep_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (bus_oe && dir_out && bus_out == rd_data));

  assert_keep_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && $past(req_ready)) |-> $stable(rd_data));
endmodule

bind mux_rd_timer mrt_chk #(.BUS_W(BUS_W)) u_mrt_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n), .bus_oe(bus_oe),
  .dir_out(dir_out), .bus_out(bus_out), .rd_valid(rd_valid),
  .rd_data(rd_data), .two_ph_q(two_ph_q)
);

// File: tb/mux_rd_timer_bench.sv
`timescale 1ns/1ps
module mux_rd_timer_bench;
  localparam int BUS_W = 16;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        cfg_two_phase = 0;
  logic [3:0]  cfg_cs_on = 0, cfg_adv_on = 0, cfg_oe_on = 0;
  logic [4:0]  cfg_cs_off = 0, cfg_adv_off = 0, cfg_oe_off = 0, cfg_acc = 0, cfg_cyc = 0;
  logic [2:0]  cfg_adv1_on = 0, cfg_adv1_off = 0, cfg_oe1_on = 0, cfg_oe1_off = 0;
  logic [15:0] bus_in = '0;
  logic [15:0] bus_out, rd_data;
  logic        bus_oe, dir_out, cs_n, adv_n, oe_n, rd_valid;

  int n_chk = 0, n_fail = 0, cycles = 0;
  logic [15:0] exp_keep = '0;

  always #10 clk = ~clk;

  mux_rd_timer u_mux_rd_timer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .cfg_two_phase(cfg_two_phase),
    .cfg_cs_on(cfg_cs_on), .cfg_cs_off(cfg_cs_off),
    .cfg_adv_on(cfg_adv_on), .cfg_adv_off(cfg_adv_off),
    .cfg_oe_on(cfg_oe_on), .cfg_oe_off(cfg_oe_off),
    .cfg_acc(cfg_acc), .cfg_cyc(cfg_cyc),
    .cfg_adv1_on(cfg_adv1_on), .cfg_adv1_off(cfg_adv1_off),
    .cfg_oe1_on(cfg_oe1_on), .cfg_oe1_off(cfg_oe1_off),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .dir_out(dir_out),
    .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit win(input int on, input int off, input int k);
    return (k >= on) && (k < off);
  endfunction

  function automatic logic [15:0] pat(input int idx, input int k);
    return 16'(32'h5A00 ^ (idx * 32'h0113) ^ (k * 32'h0901));
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic do_access(input int idx, input int i, input int j);
    int cs_on, cs_off, adv_on, adv_off, oe_on, oe_off, acc, cyc;
    int a1_on, a1_off, o1_on, o1_off;
    bit two;
    logic [31:0] addr;
    logic [15:0] eb;
    bit ad;
    cs_on = i; cs_off = j;
    adv_on = (i + 3) % 16; adv_off = (j + 7) % 32;
    oe_on = (i * 5) % 16;  oe_off = (j * 3 + 4) % 32;
    acc = (i + j) % 32;    cyc = (i + 2 * j + 5) % 32;
    two = j[0];
    a1_on = i % 8; a1_off = (j + 2) % 8; o1_on = (i + 2) % 8; o1_off = (j + i) % 8;
    addr = 32'h1234_8765 ^ (idx * 32'h0101_0303);
    // present request (negedge)
    req_valid = 1; req_addr = addr; cfg_two_phase = two;
    cfg_cs_on = 4'(cs_on); cfg_cs_off = 5'(cs_off);
    cfg_adv_on = 4'(adv_on); cfg_adv_off = 5'(adv_off);
    cfg_oe_on = 4'(oe_on); cfg_oe_off = 5'(oe_off);
    cfg_acc = 5'(acc); cfg_cyc = 5'(cyc);
    cfg_adv1_on = 3'(a1_on); cfg_adv1_off = 3'(a1_off);
    cfg_oe1_on = 3'(o1_on); cfg_oe1_off = 3'(o1_off);
    chk(req_ready == 1'b1, "R1 ready before request", req_ready, 1);
    for (int k = 0; k <= cyc; k++) begin
      @(negedge clk);
      if (k == 0) begin
        req_valid = 0;
        // R11: scramble every config and address input mid-access
        req_addr = ~addr; cfg_two_phase = ~two;
        cfg_cs_on = ~cfg_cs_on; cfg_cs_off = ~cfg_cs_off;
        cfg_adv_on = ~cfg_adv_on; cfg_adv_off = ~cfg_adv_off;
        cfg_oe_on = ~cfg_oe_on; cfg_oe_off = ~cfg_oe_off;
        cfg_acc = ~cfg_acc; cfg_cyc = ~cfg_cyc;
        cfg_adv1_on = ~cfg_adv1_on; cfg_adv1_off = ~cfg_adv1_off;
        cfg_oe1_on = ~cfg_oe1_on; cfg_oe1_off = ~cfg_oe1_off;
      end
      req_valid = (k == 1);   // R1: stray request while busy
      bus_in = pat(idx, k);
      chk(req_ready == 1'b0, "R1 busy", req_ready, 0);
      chk(rd_valid == 1'b0, "R6 no early done", rd_valid, 0);
      chk(cs_n == !win(cs_on, cs_off, k), "R2 cs_n R11", cs_n, !win(cs_on, cs_off, k));
      if (!two) begin
        chk(adv_n == !win(adv_on, adv_off, k), "R3 adv_n R11", adv_n, !win(adv_on, adv_off, k));
        chk(oe_n == !win(oe_on, oe_off, k), "R4 oe_n R11", oe_n, !win(oe_on, oe_off, k));
      end else begin
        chk(adv_n == !(win(adv_on, adv_off, k) || win(a1_on, a1_off, k)), "R8 adv_n two-phase",
            adv_n, !(win(adv_on, adv_off, k) || win(a1_on, a1_off, k)));
        chk(oe_n == !(win(oe_on, oe_off, k) || win(o1_on, o1_off, k)), "R9 oe_n two-phase",
            oe_n, !(win(oe_on, oe_off, k) || win(o1_on, o1_off, k)));
      end
      ad = (k < oe_on);
      chk(bus_oe == ad, "R5 bus_oe", bus_oe, ad);
      chk(dir_out == ad, "R5 dir_out", dir_out, ad);
      if (ad) begin
        if (two && k < o1_off) eb = addr[31:16];
        else eb = addr[15:0];
        chk(bus_out == eb, two ? "R7 address half" : "R5 address", bus_out, eb);
      end
    end
    req_valid = 0;
    @(negedge clk);
    if (acc <= cyc) exp_keep = pat(idx, acc);
    chk(rd_valid == 1'b1, "R6 done pulse", rd_valid, 1);
    chk(rd_data == exp_keep, "R6 capture", rd_data, exp_keep);
    chk(req_ready && cs_n && adv_n && oe_n, "R6 idle at done", {req_ready, cs_n, adv_n, oe_n}, 4'hF);
    chk(bus_oe && dir_out && bus_out == exp_keep, "R10 bus keeping", bus_out, exp_keep);
  endtask

  initial begin
    #25; // inside reset, away from edges
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n && adv_n && oe_n, "R12 strobes", {cs_n, adv_n, oe_n}, 3'h7);
    chk(req_ready == 1, "R12 ready", req_ready, 1);
    chk(rd_valid == 0, "R12 rd_valid", rd_valid, 0);
    chk(dir_out == 1 && bus_oe == 1, "R12 dir/oe", {dir_out, bus_oe}, 2'h3);
    chk(bus_out == 0, "R12 bus_out", bus_out, 0);
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 32; j++)
        do_access(i * 32 + j, i, j);
    // R10: idle gap keeps driving the last read value
    repeat (3) @(negedge clk);
    chk(rd_valid == 0 && bus_oe && bus_out == exp_keep, "R10 idle keep", bus_out, exp_keep);
    finish_run();
  end
endmodule